// File: doc/BRIEF.md
# Two-Way Latch/Register Bus Transceiver

This block moves an 18-bit word in two directions, from side A to side B and from side B to side A. Each direction has its own storage element. A level control chooses how that element behaves. While the level control is high, the element is a transparent path. While it is low, the element either holds its value or loads a new word on a rising edge of a capture clock. Each direction also has an output-enable input. The A-to-B enable is active high and the B-to-A enable is active low.

The block runs entirely on one fast system clock. Every input pin, including the two capture clocks, is registered once on entry. The storage elements and drive flags are registered after that. A change at an input therefore shows at the outputs exactly two system cycles later. A capture edge is recognised when the registered capture clock reads 0 on one system cycle and 1 on the next.

The outputs are a data word per direction plus a drive flag that tells the surrounding pad logic whether to drive that bus. The data word always shows the stored value, and the drive flag alone gates the pads. When both directions are told to drive at the same time, a clash flag is raised. Nothing else is done about the clash. The data pins carry no valid/ready handshake: the block is a level-controlled transceiver and never applies back-pressure.

Top module: `dual_path_xcvr`

## Requirements
- R1: The two paths are independent and each is 18 bits wide. `a_in` reaches only `b_out`, and `b_in` reaches only `a_out`.
- R2: While a direction's level control (`ab_le` / `ba_le`) is 1, its output word follows its input word.
- R3: While the level control is 0 and no capture edge is seen, the stored word is held. This applies with the capture clock resting either low or high, and input word changes have no effect.
- R4: While the level control is 0, a 0-to-1 transition of the capture clock (`ab_cap` / `ba_cap`) loads the input word present at that edge.
- R5: `b_drive` equals `ab_oe`, which is active high.
- R6: `a_drive` equals the inverse of `ba_oe_n`, which is active low. The B-to-A storage behaves as in R2 to R4 using `ba_le` and `ba_cap`.
- R7: If the level control falls while the capture clock is high, the element keeps the last word that passed through. The same holds if it falls while the capture clock is low.
- R8: A capture edge while the level control is 1 has no extra effect. The output keeps following the input.
- R9: The output enables gate only the drive flags. Storage keeps loading while a direction is disabled, and the new word is present once drive is re-enabled.
- R10: Every input change reaches the outputs exactly two system-clock cycles after it is sampled. A capture-clock pulse that is high for a single system cycle is still recognised as an edge.
- R11: A synchronous reset (`rst_n` = 0 at a clock edge) clears both stored words to 0 and both drive flags to 0.
- R12: `clash` is 1 exactly when `a_drive` and `b_drive` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 18 | Word arriving from bus A |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B level control (1 = transparent) |
| ab_cap | input | 1 | A-to-B capture clock |
| b_in | input | 18 | Word arriving from bus B |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A level control (1 = transparent) |
| ba_cap | input | 1 | B-to-A capture clock |
| b_out | output | 18 | Stored A-to-B word presented toward bus B |
| b_drive | output | 1 | Drive bus B with `b_out` |
| a_out | output | 18 | Stored B-to-A word presented toward bus A |
| a_drive | output | 1 | Drive bus A with `a_out` |
| clash | output | 1 | Both buses are being driven |

## Verification
The stored word is visible on `b_out` / `a_out` at all times, so corrupt storage shows on the port directly. A missed or spurious load appears as a wrong or changed word two cycles after the edge that caused it. A broken edge detector shows in two ways: a steady-high capture clock after the level control falls changes the word when it should not, or a single-cycle pulse loads nothing. A swapped enable polarity or a wrong pipeline depth shows on the drive flags within two cycles of the enable change.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  parameter int unsigned XCVR_W = 18;

  // Control bundle of one direction, enable already normalised to active high
  typedef struct packed {
    logic le;
    logic cap;
    logic oe;
  } lane_ctl_t;

  // What the storage element does on the coming edge
  typedef enum logic [1:0] {
    ST_KEEP = 2'd0,
    ST_PASS = 2'd1,
    ST_LOAD = 2'd2
  } store_op_t;
endpackage

// File: rtl/xcvr_sync.sv
`timescale 1ns/1ps
module xcvr_sync
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  d_pin,
  input  lane_ctl_t     ctl_pin,
  output logic [W-1:0]  d_smp,
  output lane_ctl_t     ctl_smp,
  output logic          cap_prev
);
  // One sampling stage, plus the previous sample of the capture clock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_smp    <= '0;
      ctl_smp  <= '0;
      cap_prev <= 1'b0;
    end else begin
      d_smp    <= d_pin;
      ctl_smp  <= ctl_pin;
      cap_prev <= ctl_smp.cap;
    end
  end
endmodule

// File: rtl/xcvr_store.sv
`timescale 1ns/1ps
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  d_smp,
  input  logic          le_smp,
  input  logic          cap_smp,
  input  logic          cap_prev,
  output logic [W-1:0]  q
);
  store_op_t op;
  logic      rise;

  assign rise = cap_smp & ~cap_prev;

  // Level control dominates; an edge only matters while it is low
  always_comb begin
    if (le_smp)    op = ST_PASS;
    else if (rise) op = ST_LOAD;
    else           op = ST_KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      unique case (op)
        ST_PASS, ST_LOAD: q <= d_smp;
        default:          q <= q;
      endcase
    end
  end
endmodule

// File: rtl/xcvr_lane.sv
`timescale 1ns/1ps
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int unsigned W        = XCVR_W,
  parameter bit          OE_ACT_LO = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  d_pin,
  input  logic          oe_pin,
  input  logic          le_pin,
  input  logic          cap_pin,
  output logic [W-1:0]  q,
  output logic          drive
);
  logic          oe_norm;
  lane_ctl_t     ctl_pin;
  lane_ctl_t     ctl_smp;
  logic [W-1:0]  d_smp;
  logic          cap_prev;

  generate
    if (OE_ACT_LO) begin : g_oe_low
      assign oe_norm = ~oe_pin;
    end else begin : g_oe_high
      assign oe_norm = oe_pin;
    end
  endgenerate

  assign ctl_pin = '{le: le_pin, cap: cap_pin, oe: oe_norm};

  xcvr_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_pin    (d_pin),
    .ctl_pin  (ctl_pin),
    .d_smp    (d_smp),
    .ctl_smp  (ctl_smp),
    .cap_prev (cap_prev)
  );

  xcvr_store #(.W(W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_smp    (d_smp),
    .le_smp   (ctl_smp.le),
    .cap_smp  (ctl_smp.cap),
    .cap_prev (cap_prev),
    .q        (q)
  );

  // Drive flag is aligned with the stored word
  always_ff @(posedge clk) begin
    if (!rst_n) drive <= 1'b0;
    else        drive <= ctl_smp.oe;
  end
endmodule

// File: rtl/dual_path_xcvr.sv
`timescale 1ns/1ps
module dual_path_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  a_in,
  input  logic          ab_oe,
  input  logic          ab_le,
  input  logic          ab_cap,
  input  logic [W-1:0]  b_in,
  input  logic          ba_oe_n,
  input  logic          ba_le,
  input  logic          ba_cap,
  output logic [W-1:0]  b_out,
  output logic          b_drive,
  output logic [W-1:0]  a_out,
  output logic          a_drive,
  output logic          clash
);
  xcvr_lane #(.W(W), .OE_ACT_LO(1'b0)) u_ab (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_pin   (a_in),
    .oe_pin  (ab_oe),
    .le_pin  (ab_le),
    .cap_pin (ab_cap),
    .q       (b_out),
    .drive   (b_drive)
  );

  xcvr_lane #(.W(W), .OE_ACT_LO(1'b1)) u_ba (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_pin   (b_in),
    .oe_pin  (ba_oe_n),
    .le_pin  (ba_le),
    .cap_pin (ba_cap),
    .q       (a_out),
    .drive   (a_drive)
  );

  assign clash = a_drive & b_drive;
endmodule

// File: rtl/dual_path_xcvr_chk.sv
`timescale 1ns/1ps
module dual_path_xcvr_chk #(
  parameter int unsigned W = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  a_in,
  input logic          ab_oe,
  input logic          ab_le,
  input logic          ab_cap,
  input logic [W-1:0]  b_in,
  input logic          ba_oe_n,
  input logic          ba_le,
  input logic          ba_cap,
  input logic [W-1:0]  b_out,
  input logic          b_drive,
  input logic [W-1:0]  a_out,
  input logic          a_drive,
  input logic          clash
);
  assert_reset_clear_R11: assert property (@(posedge clk)
    $past(!rst_n) |-> (b_out == '0 && a_out == '0 && !b_drive && !a_drive));

  assert_ab_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n, 1) && $past(ab_le, 2)) |-> b_out == $past(a_in, 2));

  assert_ba_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n, 1) && $past(ba_le, 2)) |-> a_out == $past(b_in, 2));

  assert_ab_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 3) && $past(rst_n, 2) && $past(rst_n, 1) && !$past(ab_le, 2)
     && !($past(ab_cap, 2) && !$past(ab_cap, 3))) |-> $stable(b_out));

  assert_ab_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 3) && $past(rst_n, 2) && $past(rst_n, 1) && !$past(ab_le, 2)
     && $past(ab_cap, 2) && !$past(ab_cap, 3)) |-> b_out == $past(a_in, 2));

  assert_ba_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 3) && $past(rst_n, 2) && $past(rst_n, 1) && !$past(ba_le, 2)
     && $past(ba_cap, 2) && !$past(ba_cap, 3)) |-> a_out == $past(b_in, 2));

  assert_b_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n, 1)) |-> b_drive == $past(ab_oe, 2));

  assert_a_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n, 1)) |-> a_drive == !$past(ba_oe_n, 2));

  assert_clash_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n, 1) && $past(ab_oe, 2) && !$past(ba_oe_n, 2)) |-> clash);

  assert_no_false_clash_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_drive && a_drive) |-> !clash);
endmodule

bind dual_path_xcvr dual_path_xcvr_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_in    (a_in),
  .ab_oe   (ab_oe),
  .ab_le   (ab_le),
  .ab_cap  (ab_cap),
  .b_in    (b_in),
  .ba_oe_n (ba_oe_n),
  .ba_le   (ba_le),
  .ba_cap  (ba_cap),
  .b_out   (b_out),
  .b_drive (b_drive),
  .a_out   (a_out),
  .a_drive (a_drive),
  .clash   (clash)
);

// File: tb/dual_path_xcvr_test.sv
`timescale 1ns/1ps
module dual_path_xcvr_test;
  localparam int W = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  a_in = '0;
  logic          ab_oe = 1'b0;
  logic          ab_le = 1'b0;
  logic          ab_cap = 1'b0;
  logic [W-1:0]  b_in = '0;
  logic          ba_oe_n = 1'b1;
  logic          ba_le = 1'b0;
  logic          ba_cap = 1'b0;
  logic [W-1:0]  b_out;
  logic          b_drive;
  logic [W-1:0]  a_out;
  logic          a_drive;
  logic          clash;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dual_path_xcvr uut (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .ab_oe(ab_oe), .ab_le(ab_le), .ab_cap(ab_cap),
    .b_in(b_in), .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_cap(ba_cap),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive),
    .clash(clash)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Two system edges: sampling stage then storage stage
  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 b_out", b_out, '0);
    check("R11 a_out", a_out, '0);
    check("R11 b_drive", {17'd0, b_drive}, '0);
    check("R11 a_drive", {17'd0, a_drive}, '0);
    check("R12 no clash after reset", {17'd0, clash}, '0);
  endtask

  task automatic t_transparent();
    ab_le = 1'b1; a_in = 18'h2A5C3; settle();
    check("R2 follow 1", b_out, 18'h2A5C3);
    a_in = 18'h15A3C; settle();
    check("R2 follow 2", b_out, 18'h15A3C);
    check("R1 a_out untouched", a_out, '0);
    // Latency: one edge later only the sampling stage moved
    a_in = 18'h3FFFF; @(negedge clk);
    check("R10 not yet", b_out, 18'h15A3C);
    @(negedge clk);
    check("R10 two cycles", b_out, 18'h3FFFF);
  endtask

  task automatic t_fall_clk_high();
    ab_le = 1'b1; a_in = 18'h01234; settle();
    ab_cap = 1'b1; a_in = 18'h04321; settle();
    check("R8 edge while transparent", b_out, 18'h04321);
    ab_le = 1'b0; settle();
    a_in = 18'h0AAAA; settle();
    check("R7 fall with clock high", b_out, 18'h04321);
    check("R3 steady high holds", b_out, 18'h04321);
  endtask

  task automatic t_fall_clk_low();
    ab_cap = 1'b0; ab_le = 1'b1; a_in = 18'h13579; settle();
    ab_le = 1'b0; settle();
    a_in = 18'h2468A; settle();
    check("R7 fall with clock low", b_out, 18'h13579);
  endtask

  task automatic t_capture();
    a_in = 18'h1BEEF; settle();
    check("R3 steady low holds", b_out, 18'h13579);
    ab_cap = 1'b1; settle();
    check("R4 rising edge loads", b_out, 18'h1BEEF);
    a_in = 18'h00F0F; settle();
    check("R3 after load holds", b_out, 18'h1BEEF);
    // Single-cycle pulse
    ab_cap = 1'b0; settle();
    a_in = 18'h3C3C3;
    ab_cap = 1'b1; @(negedge clk);
    ab_cap = 1'b0; settle();
    check("R10 one-cycle pulse loads", b_out, 18'h3C3C3);
  endtask

  task automatic t_enables();
    ab_oe = 1'b1; settle();
    check("R5 b_drive on", {17'd0, b_drive}, 18'd1);
    ab_oe = 1'b0; settle();
    check("R5 b_drive off", {17'd0, b_drive}, 18'd0);
    a_in = 18'h2D2D2; ab_cap = 1'b1; settle();
    ab_cap = 1'b0; ab_oe = 1'b1; settle();
    check("R9 loaded while disabled", b_out, 18'h2D2D2);
    check("R9 drive back", {17'd0, b_drive}, 18'd1);
    ab_oe = 1'b0; settle();
  endtask

  task automatic t_b_to_a();
    logic [W-1:0] b_keep;
    b_keep = b_out;
    ba_oe_n = 1'b0; settle();
    check("R6 a_drive low-active on", {17'd0, a_drive}, 18'd1);
    ba_le = 1'b1; b_in = 18'h31415; settle();
    check("R6 follow", a_out, 18'h31415);
    check("R1 b_out untouched", b_out, b_keep);
    ba_le = 1'b0; settle();
    b_in = 18'h27182; settle();
    check("R6 hold", a_out, 18'h31415);
    ba_cap = 1'b1; settle();
    check("R6 capture", a_out, 18'h27182);
    ba_cap = 1'b0;
    ba_oe_n = 1'b1; settle();
    check("R6 a_drive off", {17'd0, a_drive}, 18'd0);
  endtask

  task automatic t_clash();
    ab_oe = 1'b1; ba_oe_n = 1'b0; settle();
    check("R12 clash raised", {17'd0, clash}, 18'd1);
    ba_oe_n = 1'b1; settle();
    check("R12 clash cleared", {17'd0, clash}, 18'd0);
    ab_oe = 1'b0; settle();
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_transparent();
    t_fall_clk_high();
    t_fall_clk_low();
    t_capture();
    t_enables();
    t_b_to_a();
    t_clash();
    rst_n = 1'b0; settle();
    t_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule